// File: doc/BRIEF.md
# Bit-Addressable Data Memory with Port Registers

This block is the on-chip data store of a small 8-bit controller. It holds a 256-byte register space reached through an 8-bit address. Four locations in the upper half are port registers: reading one returns the live external input pins, and writing one updates an output latch that drives a pin bus out of the block.

Accesses are either whole bytes or single bits. A bit-mode flag reinterprets the address as a bit number. The lower half of bit numbers covers a sixteen-byte window of ordinary storage. The upper half covers every register whose address is a multiple of eight. A bit write changes only the addressed bit in the same clock. Read and write strobes are active low and are sampled at the rising clock edge. Read data is registered, so it appears one cycle after the strobe is sampled.

Top module: `bit_data_mem`

## Requirements
- R1: A byte write (wr_ni low, bit_mode_i low) stores wdata_i at addr_i. A later byte read (rd_ni low, bit_mode_i low) of that address shows it on rdata_o after the rising edge that samples the strobe.
- R2: With rd_ni high, rdata_o and bit_rdata_o hold their values. With wr_ni high, nothing is stored.
- R3: While rst_ni is low, every storage byte becomes 0x00, rdata_o and bit_rdata_o become 0, and every port output latch becomes 0xFF.
- R4: In bit mode, an address below 0x80 names bit addr_i[2:0] of byte 0x20 + addr_i[6:3].
- R5: In bit mode, an address of 0x80 or above names bit addr_i[2:0] of the byte at addr_i with its low three bits cleared.
- R6: A bit write (wr_ni low, bit_mode_i high) sets the named bit to bit_wdata_i and leaves the other seven bits of that byte unchanged.
- R7: Port k (k = 0..3) sits at byte address 0x80 + 16*k. A read of a port address returns pin_i[8k+7:8k] as sampled at the edge. This holds for byte reads and for bit reads.
- R8: A byte write to port k sets pout_o[8k+7:8k] to wdata_i one edge later. A bit write to port k changes only the named bit of that latch.
- R9: When both strobes are low in the same cycle, the write takes effect and the read returns the value held before that write.
- R10: Writes to addresses that are not port addresses leave pout_o unchanged.
- R11: A bit read updates only bit_rdata_o. A byte read updates only rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address, or bit number in bit mode |
| bit_mode_i | input | 1 | High selects single-bit access |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| wdata_i | input | 8 | Byte write data |
| bit_wdata_i | input | 1 | Bit write data |
| rdata_o | output | 8 | Registered byte read data |
| bit_rdata_o | output | 1 | Registered bit read data |
| pin_i | input | 32 | Port input pins, port k in bits 8k+7:8k |
| pout_o | output | 32 | Port output latches, port k in bits 8k+7:8k |

## Verification
The assertions check these rules on every cycle:
- the read outputs hold while no read strobe is present;
- a bit read leaves the byte output alone, and a byte read leaves the bit output alone;
- a bit write flips at most one output-latch bit;
- a write to a non-port address never moves the port outputs;
- a port read returns the sampled pins;
- a byte write to a port lands in the right latch.

Only the directed scenarios can show the following:
- where each bit number lands in the two bit-address halves;
- that stored bytes survive read-back;
- the old-value result of a simultaneous read and write;
- the full clearing by reset.

// File: rtl/bdm_pkg.sv
package bdm_pkg;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int SW = $clog2(DW);

  typedef struct packed {
    logic [AW-1:0] byte_addr;
    logic [SW-1:0] bit_sel;
    logic          is_port;
    logic [2:0]    port_idx;
  } acc_t;
endpackage

// File: rtl/bdm_decode.sv
module bdm_decode
  import bdm_pkg::*;
#(
  parameter int            NP       = 4,
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  logic [AW-1:0] addr_i,
  input  logic          bit_mode_i,
  output acc_t          acc_o
);
  always_comb begin
    acc_o = '0;
    if (bit_mode_i) begin
      acc_o.bit_sel = addr_i[SW-1:0];
      if (addr_i[AW-1]) acc_o.byte_addr = {addr_i[AW-1:SW], {SW{1'b0}}};
      else              acc_o.byte_addr = BIT_BASE + {4'b0, addr_i[6:3]};
    end else begin
      acc_o.byte_addr = addr_i;
    end
    acc_o.port_idx = acc_o.byte_addr[6:4];
    // port registers live at 0x80 + 16*k
    acc_o.is_port  = acc_o.byte_addr[7] && (acc_o.byte_addr[3:0] == 4'h0)
                     && (int'(acc_o.byte_addr[6:4]) < NP);
  end
endmodule

// File: rtl/bdm_store.sv
module bdm_store
  import bdm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          bit_we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [SW-1:0] bit_sel_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          bit_wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[addr_i] <= wdata_i;
    end else if (bit_we_i) begin
      mem_q[addr_i][bit_sel_i] <= bit_wdata_i;
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/bdm_ports.sv
module bdm_ports
  import bdm_pkg::*;
#(
  parameter int NP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic            bit_we_i,
  input  logic [2:0]      idx_i,
  input  logic [SW-1:0]   bit_sel_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            bit_wdata_i,
  input  logic [NP*DW-1:0] pin_i,
  output logic [NP*DW-1:0] pout_o,
  output logic [DW-1:0]   pin_sel_o
);
  for (genvar k = 0; k < NP; k++) begin : g_port
    logic [DW-1:0] latch_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  latch_q <= '1;
      else if (we_i && idx_i == 3'(k))              latch_q <= wdata_i;
      else if (bit_we_i && idx_i == 3'(k))          latch_q[bit_sel_i] <= bit_wdata_i;
    end
    assign pout_o[k*DW +: DW] = latch_q;
  end

  always_comb begin
    pin_sel_o = '0;
    for (int k = 0; k < NP; k++)
      if (idx_i == 3'(k)) pin_sel_o = pin_i[k*DW +: DW];
  end
endmodule

// File: rtl/bit_data_mem.sv
module bit_data_mem
  import bdm_pkg::*;
#(
  parameter int            NP       = 4,
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             bit_mode_i,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [DW-1:0]    wdata_i,
  input  logic             bit_wdata_i,
  output logic [DW-1:0]    rdata_o,
  output logic             bit_rdata_o,
  input  logic [NP*DW-1:0] pin_i,
  output logic [NP*DW-1:0] pout_o
);
  acc_t          acc;
  logic [DW-1:0] mem_rd, pin_sel, cur_byte;
  logic          wr, rd;

  assign wr = !wr_ni;
  assign rd = !rd_ni;

  bdm_decode #(.NP(NP), .BIT_BASE(BIT_BASE)) u_dec (
    .addr_i(addr_i), .bit_mode_i(bit_mode_i), .acc_o(acc)
  );

  bdm_store u_store (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr && !bit_mode_i && !acc.is_port),
    .bit_we_i(wr && bit_mode_i && !acc.is_port),
    .addr_i(acc.byte_addr), .bit_sel_i(acc.bit_sel),
    .wdata_i(wdata_i), .bit_wdata_i(bit_wdata_i), .rdata_o(mem_rd)
  );

  bdm_ports #(.NP(NP)) u_ports (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr && !bit_mode_i && acc.is_port),
    .bit_we_i(wr && bit_mode_i && acc.is_port),
    .idx_i(acc.port_idx), .bit_sel_i(acc.bit_sel),
    .wdata_i(wdata_i), .bit_wdata_i(bit_wdata_i),
    .pin_i(pin_i), .pout_o(pout_o), .pin_sel_o(pin_sel)
  );

  // port reads see pins, not the latch
  assign cur_byte = acc.is_port ? pin_sel : mem_rd;

  // registered read: a same-edge write is not yet visible, so old data returns
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      bit_rdata_o <= 1'b0;
    end else if (rd) begin
      if (bit_mode_i) bit_rdata_o <= cur_byte[acc.bit_sel];
      else            rdata_o     <= cur_byte;
    end
  end
endmodule

// File: rtl/bdm_chk.sv
module bdm_chk #(
  parameter int NP = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [7:0]       addr_i,
  input logic             bit_mode_i,
  input logic             rd_ni,
  input logic             wr_ni,
  input logic [7:0]       wdata_i,
  input logic [7:0]       rdata_o,
  input logic             bit_rdata_o,
  input logic [NP*8-1:0]  pin_i,
  input logic [NP*8-1:0]  pout_o
);
  logic       port_hit;
  logic [7:0] pin_at_addr, pout_at_prev;
  logic [2:0] idx_q;

  assign port_hit = addr_i[7] && !addr_i[3] && (int'(addr_i[6:4]) < NP)
                    && (bit_mode_i || addr_i[2:0] == 3'b0);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) idx_q <= '0;
    else         idx_q <= addr_i[6:4];

  always_comb begin
    pin_at_addr  = '0;
    pout_at_prev = '0;
    for (int k = 0; k < NP; k++) begin
      if (addr_i[6:4] == 3'(k)) pin_at_addr  = pin_i[k*8 +: 8];
      if (idx_q == 3'(k))       pout_at_prev = pout_o[k*8 +: 8];
    end
  end

  assert_rd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ni |=> ($stable(rdata_o) && $stable(bit_rdata_o)));

  assert_bit_rd_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ni && bit_mode_i) |=> $stable(rdata_o));

  assert_byte_rd_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ni && !bit_mode_i) |=> $stable(bit_rdata_o));

  assert_bit_wr_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && bit_mode_i) |=> ($countones(pout_o ^ $past(pout_o)) <= 1));

  assert_port_rd_pins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ni && !bit_mode_i && port_hit) |=> (rdata_o == $past(pin_at_addr)));

  assert_port_wr_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ni && !bit_mode_i && port_hit) |=> (pout_at_prev == $past(wdata_i)));

  assert_no_port_side_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ni || !port_hit) |=> $stable(pout_o));
endmodule

bind bit_data_mem bdm_chk #(.NP(NP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .bit_mode_i(bit_mode_i),
  .rd_ni(rd_ni), .wr_ni(wr_ni), .wdata_i(wdata_i), .rdata_o(rdata_o),
  .bit_rdata_o(bit_rdata_o), .pin_i(pin_i), .pout_o(pout_o)
);

// File: tb/sim_bit_data_mem.sv
module sim_bit_data_mem;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        bit_mode_i = 1'b0;
  logic        rd_ni = 1'b1;
  logic        wr_ni = 1'b1;
  logic [7:0]  wdata_i = '0;
  logic        bit_wdata_i = 1'b0;
  logic [7:0]  rdata_o;
  logic        bit_rdata_o;
  logic [31:0] pin_i = '0;
  logic [31:0] pout_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  bit_data_mem u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(bit rd, bit wr, bit bm, logic [7:0] a, logic [7:0] d, bit bd);
    @(negedge clk_i);
    rd_ni = !rd; wr_ni = !wr; bit_mode_i = bm;
    addr_i = a; wdata_i = d; bit_wdata_i = bd;
    @(negedge clk_i);
    rd_ni = 1'b1; wr_ni = 1'b1;
  endtask

  task automatic wr_b(logic [7:0] a, logic [7:0] d); op(0, 1, 0, a, d, 0); endtask
  task automatic rd_b(logic [7:0] a);                op(1, 0, 0, a, 0, 0); endtask
  task automatic wr_bit(logic [7:0] a, bit d);       op(0, 1, 1, a, 0, d); endtask
  task automatic rd_bit(logic [7:0] a);              op(1, 0, 1, a, 0, 0); endtask

  task automatic t_reset;
    chk("R3 rdata", rdata_o, 0);
    chk("R3 bit", bit_rdata_o, 0);
    chk("R3 pout", pout_o, 32'hFFFF_FFFF);
    rd_b(8'h30); chk("R3 mem", rdata_o, 8'h00);
  endtask

  task automatic t_bytes;
    wr_b(8'h05, 8'hA5); wr_b(8'h7F, 8'h3C); wr_b(8'hC3, 8'h77);
    rd_b(8'h05); chk("R1 0x05", rdata_o, 8'hA5);
    rd_b(8'h7F); chk("R1 0x7F", rdata_o, 8'h3C);
    rd_b(8'hC3); chk("R1 0xC3", rdata_o, 8'h77);
  endtask

  task automatic t_idle;
    @(negedge clk_i); addr_i = 8'h05; rd_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk("R2 hold", rdata_o, 8'h77);
    op(0, 0, 0, 8'h05, 8'h11, 0);
    rd_b(8'h05); chk("R2 no write", rdata_o, 8'hA5);
  endtask

  task automatic t_bit_low;
    wr_b(8'h21, 8'h00); wr_bit(8'h0B, 1);
    rd_b(8'h21); chk("R4 R6 set 0x21.3", rdata_o, 8'h08);
    rd_bit(8'h0B); chk("R4 bit rd 0x0B", bit_rdata_o, 1);
    rd_bit(8'h0A); chk("R4 bit rd 0x0A", bit_rdata_o, 0);
    wr_b(8'h2F, 8'h80);
    rd_bit(8'h7F); chk("R4 bit rd 0x7F", bit_rdata_o, 1);
    rd_bit(8'h7E); chk("R4 bit rd 0x7E", bit_rdata_o, 0);
  endtask

  task automatic t_bit_high;
    wr_b(8'hC8, 8'h00); wr_bit(8'hCD, 1);
    rd_b(8'hC8); chk("R5 set 0xC8.5", rdata_o, 8'h20);
    wr_b(8'hC8, 8'hFF); wr_bit(8'hCA, 0);
    rd_b(8'hC8); chk("R6 clear 0xC8.2", rdata_o, 8'hFB);
  endtask

  task automatic t_ports;
    pin_i = 32'h1234_5678;
    rd_b(8'h90); chk("R7 port1 byte", rdata_o, 8'h56);
    rd_bit(8'h84); chk("R7 port0 bit4", bit_rdata_o, 1);
    rd_bit(8'h83); chk("R7 port0 bit3", bit_rdata_o, 1);
    rd_bit(8'h80); chk("R7 port0 bit0", bit_rdata_o, 0);
    wr_b(8'hA0, 8'h5A); chk("R8 port2 byte", pout_o, 32'hFF5A_FFFF);
    wr_bit(8'hB3, 0);   chk("R8 R6 port3 bit3", pout_o, 32'hF75A_FFFF);
  endtask

  task automatic t_collide;
    wr_b(8'h40, 8'h11);
    op(1, 1, 0, 8'h40, 8'h22, 0); chk("R9 old value", rdata_o, 8'h11);
    rd_b(8'h40); chk("R9 new stored", rdata_o, 8'h22);
  endtask

  task automatic t_modes;
    rd_bit(8'h0B); chk("R11 bit rd", bit_rdata_o, 1);
    rd_b(8'h05);   chk("R11 byte rd", rdata_o, 8'hA5);
    chk("R11 bit kept", bit_rdata_o, 1);
    rd_bit(8'h0A); chk("R11 byte kept", rdata_o, 8'hA5);
    chk("R11 bit upd", bit_rdata_o, 0);
  endtask

  task automatic t_non_port;
    wr_b(8'h81, 8'h3E); chk("R10 byte 0x81", pout_o, 32'hF75A_FFFF);
    wr_b(8'h88, 8'h00); wr_bit(8'h8B, 1);
    chk("R10 bit 0x88.3", pout_o, 32'hF75A_FFFF);
    rd_b(8'h81); chk("R10 0x81 stored", rdata_o, 8'h3E);
    rd_b(8'h88); chk("R10 0x88 stored", rdata_o, 8'h08);
  endtask

  task automatic t_rereset;
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R3 pout again", pout_o, 32'hFFFF_FFFF);
    chk("R3 rdata again", rdata_o, 0);
    rst_ni = 1'b1;
    rd_b(8'h05); chk("R3 mem cleared", rdata_o, 8'h00);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_bytes();
    t_idle();
    t_bit_low();
    t_bit_high();
    t_ports();
    t_collide();
    t_modes();
    t_non_port();
    t_rereset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule